// File: doc/BRIEF.md
# Masked Shared-Bus Interconnect

This block joins a set of bus masters to a set of bus slaves over a single shared path that follows the classic Wishbone handshake. One master at a time owns the bus. Its address is compared against a window for each slave and its strobe is steered to exactly one of them. The reply from that slave (acknowledge, error and read data) is routed back to the owning master only. The request path and the reply path are combinational. The only storage is a small ownership register that keeps the current master on the bus for the whole of its cycle.

The master count and the slave count are separate parameters. Each side has an enable vector in which bit i stands for slot i. A cleared bit removes that slot's arbitration, decode and multiplexing logic entirely: the slot's inputs go nowhere and its outputs are tied low. This lets a design keep fixed slot numbering with a sparsely populated array at no hardware cost. Every enabled slave slot carries a base address and an address mask. A request that lands in no enabled window is answered with an error on the same cycle, so the master never waits forever.

Top module: `busfab_shared`

## Requirements
- R1: While no enabled master holds CYC high, every s_cyc and s_stb bit is low and every m_ack and m_err bit is low. This holds during reset as well.
- R2: A request from the owning master goes to the enabled slave slot j for which (address & SLV_MASK[j]) == SLV_BASE[j]. Only s_cyc[j] and s_stb[j] rise. The default map is: slot 0 base 0x0000 mask 0xF000; slot 1 base 0x1000 mask 0xF000; slot 2 base 0x0000 mask 0xC000; slot 3 base 0x4000 mask 0xF000.
- R3: When the windows of several enabled slots match, the lowest-indexed slot is selected. With the default map, 0x0123 goes to slot 0 and not slot 2.
- R4: The owning master receives m_ack and m_dat_r from the selected slave on the same cycle. Every other master sees m_ack low and m_dat_r zero.
- R5: Address, write data, write enable and byte selects of the owning master appear on s_adr, s_dat_w, s_we and s_sel of the enabled slave slots. A write reaches only the selected slave's strobe.
- R6: A strobe from the owning master whose address matches no enabled window raises m_err for that master on the same cycle. No s_cyc bit rises and m_ack stays low.
- R7: When several enabled masters raise CYC and none owns the bus, the lowest-indexed one is granted.
- R8: Once granted, a master keeps the bus until it drops CYC, even if a lower-indexed master raises CYC in the meantime.
- R9: A master slot whose bit in MST_EN (bit i = master i) is 0 is never granted. Its CYC is ignored, and its m_ack, m_err and m_dat_r are held at zero. The default MST_EN is 4'b1011, which disables master 2.
- R10: A slave slot whose bit in SLV_EN (bit j = slave j) is 0 has s_cyc, s_stb, s_adr and s_dat_w held at zero. Its s_ack, s_err and s_dat_r are ignored, and its window counts as unmapped. The default SLV_EN is 4'b0111, which disables slave 3.
- R11: s_err from the selected slave reaches the owning master as m_err, with m_ack low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the ownership register |
| rst | input | 1 | Synchronous active-high reset, clears ownership |
| m_cyc | input | NM | Bus cycle request, one bit per master |
| m_stb | input | NM | Strobe, one bit per master |
| m_we | input | NM | Write enable, one bit per master |
| m_adr | input | NM x AW | Address of each master |
| m_dat_w | input | NM x DW | Write data of each master |
| m_sel | input | NM x DW/8 | Byte selects of each master |
| m_ack | output | NM | Acknowledge to each master |
| m_err | output | NM | Error to each master |
| m_dat_r | output | NM x DW | Read data to each master |
| s_cyc | output | NS | Cycle to each slave |
| s_stb | output | NS | Strobe to each slave |
| s_we | output | NS | Write enable to each slave |
| s_adr | output | NS x AW | Address to each slave |
| s_dat_w | output | NS x DW | Write data to each slave |
| s_sel | output | NS x DW/8 | Byte selects to each slave |
| s_ack | input | NS | Acknowledge from each slave |
| s_err | input | NS | Error from each slave |
| s_dat_r | input | NS x DW | Read data from each slave |

## Verification
The properties assume well-behaved masters and slaves. A master keeps CYC high from its strobe until its acknowledge or error. A slave answers only while its own s_cyc and s_stb are high. Under these conditions the one-reply and ownership-hold properties describe the bus and not a glitching source. The stimulus changes master inputs only on the falling edge, holds each request steady across at least one rising edge, and models slaves that answer only when strobed. The one exception is the disabled slave, which acknowledges constantly; this is allowed only because its replies must never reach a master.

// File: rtl/busfab_pkg.sv
package busfab_pkg;

   // Upper bound on slot counts on either side of the fabric
   localparam int unsigned MAX_SLOTS = 32;

   // Width of an index that can address n slots (minimum 1 bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/busfab_arb.sv
module busfab_arb
   import busfab_pkg::*;
#(
   parameter int unsigned       NM     = 4,
   parameter logic [NM-1:0]     MST_EN = '1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NM-1:0] req,
   output logic [NM-1:0] gnt
);
   localparam int unsigned IW = idx_width(NM);

   logic [NM-1:0] req_eff;
   logic [NM-1:0] fresh;
   logic [IW-1:0] owner_q;
   logic          own_vld_q;
   logic [IW-1:0] gnt_idx;
   logic          keep;

   // Disabled master slots contribute no request logic at all
   for (genvar i = 0; i < NM; i++) begin : g_req
      if (MST_EN[i]) begin : g_on
         assign req_eff[i] = req[i];
      end else begin : g_off
         logic unused_ok;
         assign unused_ok  = req[i];
         assign req_eff[i] = 1'b0;
      end
   end

   // Fixed priority: lowest index wins when nobody holds the bus
   always_comb begin
      fresh = '0;
      for (int i = NM - 1; i >= 0; i--) begin
         if (req_eff[i]) fresh = NM'(1) << i;
      end
   end

   assign keep = own_vld_q && req_eff[owner_q];
   assign gnt  = keep ? (NM'(1) << owner_q) : fresh;

   always_comb begin
      gnt_idx = '0;
      for (int i = 0; i < NM; i++) begin
         if (gnt[i]) gnt_idx = IW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         own_vld_q <= 1'b0;
         owner_q   <= '0;
      end else begin
         own_vld_q <= |gnt;
         owner_q   <= gnt_idx;
      end
   end

endmodule

// File: rtl/busfab_req_mux.sv
module busfab_req_mux #(
   parameter int unsigned   NM     = 4,
   parameter int unsigned   AW     = 16,
   parameter int unsigned   DW     = 32,
   parameter int unsigned   SW     = DW / 8,
   parameter logic [NM-1:0] MST_EN = '1
) (
   input  logic [NM-1:0]         gnt,
   input  logic [NM-1:0]         m_stb,
   input  logic [NM-1:0]         m_we,
   input  logic [NM-1:0][AW-1:0] m_adr,
   input  logic [NM-1:0][DW-1:0] m_dat_w,
   input  logic [NM-1:0][SW-1:0] m_sel,
   output logic                  g_stb,
   output logic                  g_we,
   output logic [AW-1:0]         g_adr,
   output logic [DW-1:0]         g_dat_w,
   output logic [SW-1:0]         g_sel
);
   logic [NM-1:0]         c_stb;
   logic [NM-1:0]         c_we;
   logic [NM-1:0][AW-1:0] c_adr;
   logic [NM-1:0][DW-1:0] c_dat;
   logic [NM-1:0][SW-1:0] c_sel;

   for (genvar i = 0; i < NM; i++) begin : g_src
      if (MST_EN[i]) begin : g_on
         assign c_stb[i] = gnt[i] & m_stb[i];
         assign c_we[i]  = gnt[i] & m_we[i];
         assign c_adr[i] = gnt[i] ? m_adr[i]   : '0;
         assign c_dat[i] = gnt[i] ? m_dat_w[i] : '0;
         assign c_sel[i] = gnt[i] ? m_sel[i]   : '0;
      end else begin : g_off
         logic unused_ok;
         assign unused_ok = ^{gnt[i], m_stb[i], m_we[i], m_adr[i], m_dat_w[i], m_sel[i]};
         assign c_stb[i]  = 1'b0;
         assign c_we[i]   = 1'b0;
         assign c_adr[i]  = '0;
         assign c_dat[i]  = '0;
         assign c_sel[i]  = '0;
      end
   end

   // AND-OR merge; grant is one-hot so at most one term is non-zero
   always_comb begin
      g_adr   = '0;
      g_dat_w = '0;
      g_sel   = '0;
      for (int i = 0; i < NM; i++) begin
         g_adr   = g_adr   | c_adr[i];
         g_dat_w = g_dat_w | c_dat[i];
         g_sel   = g_sel   | c_sel[i];
      end
   end

   assign g_stb = |c_stb;
   assign g_we  = |c_we;

endmodule

// File: rtl/busfab_dec.sv
module busfab_dec #(
   parameter int unsigned             NS       = 4,
   parameter int unsigned             AW       = 16,
   parameter logic [NS-1:0]           SLV_EN   = '1,
   parameter logic [NS-1:0][AW-1:0]   SLV_BASE = '0,
   parameter logic [NS-1:0][AW-1:0]   SLV_MASK = '0
) (
   input  logic [AW-1:0] adr,
   output logic [NS-1:0] sel,
   output logic          hit_any
);
   logic [NS-1:0] hit;

   for (genvar j = 0; j < NS; j++) begin : g_win
      if (SLV_EN[j]) begin : g_on
         assign hit[j] = ((adr & SLV_MASK[j]) == SLV_BASE[j]);
      end else begin : g_off
         assign hit[j] = 1'b0;
      end
   end

   // Lowest-indexed matching window takes the request
   always_comb begin
      sel = '0;
      for (int j = NS - 1; j >= 0; j--) begin
         if (hit[j]) sel = NS'(1) << j;
      end
   end

   assign hit_any = |hit;

endmodule

// File: rtl/busfab_ret.sv
module busfab_ret #(
   parameter int unsigned   NS     = 4,
   parameter int unsigned   DW     = 32,
   parameter logic [NS-1:0] SLV_EN = '1
) (
   input  logic [NS-1:0]         sel,
   input  logic [NS-1:0]         s_ack,
   input  logic [NS-1:0]         s_err,
   input  logic [NS-1:0][DW-1:0] s_dat_r,
   output logic                  r_ack,
   output logic                  r_err,
   output logic [DW-1:0]         r_dat
);
   logic [NS-1:0]         c_ack;
   logic [NS-1:0]         c_err;
   logic [NS-1:0][DW-1:0] c_dat;

   for (genvar j = 0; j < NS; j++) begin : g_rsp
      if (SLV_EN[j]) begin : g_on
         assign c_ack[j] = sel[j] & s_ack[j];
         assign c_err[j] = sel[j] & s_err[j];
         assign c_dat[j] = sel[j] ? s_dat_r[j] : '0;
      end else begin : g_off
         logic unused_ok;
         assign unused_ok = ^{sel[j], s_ack[j], s_err[j], s_dat_r[j]};
         assign c_ack[j]  = 1'b0;
         assign c_err[j]  = 1'b0;
         assign c_dat[j]  = '0;
      end
   end

   always_comb begin
      r_dat = '0;
      for (int j = 0; j < NS; j++) begin
         r_dat = r_dat | c_dat[j];
      end
   end

   assign r_ack = |c_ack;
   assign r_err = |c_err;

endmodule

// File: rtl/busfab_shared.sv
module busfab_shared
   import busfab_pkg::*;
#(
   parameter int unsigned           NM       = 4,
   parameter int unsigned           NS       = 4,
   parameter int unsigned           AW       = 16,
   parameter int unsigned           DW       = 32,
   parameter logic [NM-1:0]         MST_EN   = 4'b1011,
   parameter logic [NS-1:0]         SLV_EN   = 4'b0111,
   parameter logic [NS-1:0][AW-1:0] SLV_BASE = {16'h4000, 16'h0000, 16'h1000, 16'h0000},
   parameter logic [NS-1:0][AW-1:0] SLV_MASK = {16'hF000, 16'hC000, 16'hF000, 16'hF000},
   localparam int unsigned          SW       = DW / 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NM-1:0]         m_cyc,
   input  logic [NM-1:0]         m_stb,
   input  logic [NM-1:0]         m_we,
   input  logic [NM-1:0][AW-1:0] m_adr,
   input  logic [NM-1:0][DW-1:0] m_dat_w,
   input  logic [NM-1:0][SW-1:0] m_sel,
   output logic [NM-1:0]         m_ack,
   output logic [NM-1:0]         m_err,
   output logic [NM-1:0][DW-1:0] m_dat_r,
   output logic [NS-1:0]         s_cyc,
   output logic [NS-1:0]         s_stb,
   output logic [NS-1:0]         s_we,
   output logic [NS-1:0][AW-1:0] s_adr,
   output logic [NS-1:0][DW-1:0] s_dat_w,
   output logic [NS-1:0][SW-1:0] s_sel,
   input  logic [NS-1:0]         s_ack,
   input  logic [NS-1:0]         s_err,
   input  logic [NS-1:0][DW-1:0] s_dat_r
);
   // Elaboration-time parameter checks
   if (NM < 1 || NM > MAX_SLOTS) begin : g_bad_nm
      $error("busfab_shared: master count out of range");
   end
   if (NS < 1 || NS > MAX_SLOTS) begin : g_bad_ns
      $error("busfab_shared: slave count out of range");
   end
   if (DW % 8 != 0 || DW == 0) begin : g_bad_dw
      $error("busfab_shared: data width must be a whole number of bytes");
   end
   if (MST_EN == '0) begin : g_bad_men
      $error("busfab_shared: no master slot enabled");
   end
   if (SLV_EN == '0) begin : g_bad_sen
      $error("busfab_shared: no slave slot enabled");
   end
   for (genvar j = 0; j < NS; j++) begin : g_chk_win
      if (SLV_EN[j] && ((SLV_BASE[j] & ~SLV_MASK[j]) != '0)) begin : g_bad_win
         $error("busfab_shared: slave base has bits outside its mask");
      end
   end

   logic [NM-1:0] gnt;
   logic          busy;
   logic          g_stb;
   logic          g_we;
   logic [AW-1:0] g_adr;
   logic [DW-1:0] g_dat_w;
   logic [SW-1:0] g_sel;
   logic [NS-1:0] sel;
   logic          hit_any;
   logic          r_ack;
   logic          r_err;
   logic [DW-1:0] r_dat;
   logic          miss;

   busfab_arb #(
      .NM     (NM),
      .MST_EN (MST_EN)
   ) u_arb (
      .clk (clk),
      .rst (rst),
      .req (m_cyc),
      .gnt (gnt)
   );

   busfab_req_mux #(
      .NM     (NM),
      .AW     (AW),
      .DW     (DW),
      .SW     (SW),
      .MST_EN (MST_EN)
   ) u_req (
      .gnt     (gnt),
      .m_stb   (m_stb),
      .m_we    (m_we),
      .m_adr   (m_adr),
      .m_dat_w (m_dat_w),
      .m_sel   (m_sel),
      .g_stb   (g_stb),
      .g_we    (g_we),
      .g_adr   (g_adr),
      .g_dat_w (g_dat_w),
      .g_sel   (g_sel)
   );

   busfab_dec #(
      .NS       (NS),
      .AW       (AW),
      .SLV_EN   (SLV_EN),
      .SLV_BASE (SLV_BASE),
      .SLV_MASK (SLV_MASK)
   ) u_dec (
      .adr     (g_adr),
      .sel     (sel),
      .hit_any (hit_any)
   );

   busfab_ret #(
      .NS     (NS),
      .DW     (DW),
      .SLV_EN (SLV_EN)
   ) u_ret (
      .sel     (sel),
      .s_ack   (s_ack),
      .s_err   (s_err),
      .s_dat_r (s_dat_r),
      .r_ack   (r_ack),
      .r_err   (r_err),
      .r_dat   (r_dat)
   );

   assign busy = |gnt;
   assign miss = busy & g_stb & ~hit_any;

   // Slave-side drive: enabled slots share the owner's request, disabled slots stay at zero
   for (genvar j = 0; j < NS; j++) begin : g_slv
      if (SLV_EN[j]) begin : g_on
         assign s_cyc[j]   = busy & sel[j];
         assign s_stb[j]   = busy & sel[j] & g_stb;
         assign s_we[j]    = g_we;
         assign s_adr[j]   = g_adr;
         assign s_dat_w[j] = g_dat_w;
         assign s_sel[j]   = g_sel;
      end else begin : g_off
         assign s_cyc[j]   = 1'b0;
         assign s_stb[j]   = 1'b0;
         assign s_we[j]    = 1'b0;
         assign s_adr[j]   = '0;
         assign s_dat_w[j] = '0;
         assign s_sel[j]   = '0;
      end
   end

   // Master-side reply: only the owner sees the selected slave's answer
   for (genvar i = 0; i < NM; i++) begin : g_mst
      if (MST_EN[i]) begin : g_on
         assign m_ack[i]   = gnt[i] & r_ack;
         assign m_err[i]   = gnt[i] & (r_err | miss);
         assign m_dat_r[i] = gnt[i] ? r_dat : '0;
      end else begin : g_off
         assign m_ack[i]   = 1'b0;
         assign m_err[i]   = 1'b0;
         assign m_dat_r[i] = '0;
      end
   end

endmodule

// File: rtl/busfab_shared_chk.sv
module busfab_shared_chk #(
   parameter int unsigned   NM     = 4,
   parameter int unsigned   NS     = 4,
   parameter logic [NM-1:0] MST_EN = '1,
   parameter logic [NS-1:0] SLV_EN = '1
) (
   input logic          clk,
   input logic          rst,
   input logic [NM-1:0] m_cyc,
   input logic [NM-1:0] m_stb,
   input logic [NM-1:0] m_ack,
   input logic [NM-1:0] m_err,
   input logic [NS-1:0] s_cyc,
   input logic [NS-1:0] s_stb,
   input logic [NM-1:0] gnt
);

   // R2
   one_slave_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(s_cyc));

   // R4
   one_reply_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(m_ack | m_err));

   // R7
   idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt & ~m_cyc) == '0);

   // R6
   unmapped_err_chk: assert property (@(posedge clk) disable iff (rst)
      ((|(gnt & m_stb)) && !(|s_cyc)) |-> (|(gnt & m_err)));

   // R9
   masked_master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ((m_ack | m_err | gnt) & ~MST_EN) == '0);

   // R10
   masked_slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ((s_cyc | s_stb) & ~SLV_EN) == '0);

   for (genvar i = 0; i < NM; i++) begin : g_hold
      // R8
      hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
         (gnt[i] && m_cyc[i]) |=> (!m_cyc[i] || gnt[i]));
   end

endmodule

bind busfab_shared busfab_shared_chk #(
   .NM     (NM),
   .NS     (NS),
   .MST_EN (MST_EN),
   .SLV_EN (SLV_EN)
) i_chk (
   .clk   (clk),
   .rst   (rst),
   .m_cyc (m_cyc),
   .m_stb (m_stb),
   .m_ack (m_ack),
   .m_err (m_err),
   .s_cyc (s_cyc),
   .s_stb (s_stb),
   .gnt   (gnt)
);

// File: tb/test_busfab_shared.sv
`timescale 1ns/1ps
module test_busfab_shared;
   localparam int NM = 4;
   localparam int NS = 4;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int SW = DW / 8;

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic [NM-1:0]         m_cyc = '0;
   logic [NM-1:0]         m_stb = '0;
   logic [NM-1:0]         m_we = '0;
   logic [NM-1:0][AW-1:0] m_adr = '0;
   logic [NM-1:0][DW-1:0] m_dat_w = '0;
   logic [NM-1:0][SW-1:0] m_sel = '0;
   logic [NM-1:0]         m_ack;
   logic [NM-1:0]         m_err;
   logic [NM-1:0][DW-1:0] m_dat_r;
   logic [NS-1:0]         s_cyc;
   logic [NS-1:0]         s_stb;
   logic [NS-1:0]         s_we;
   logic [NS-1:0][AW-1:0] s_adr;
   logic [NS-1:0][DW-1:0] s_dat_w;
   logic [NS-1:0][SW-1:0] s_sel;
   logic [NS-1:0]         s_ack;
   logic [NS-1:0]         s_err;
   logic [NS-1:0][DW-1:0] s_dat_r;
   logic [NS-1:0]         force_err = '0;
   logic [NS-1:0][DW-1:0] wr_last;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   busfab_shared i_busfab_shared (
      .clk (clk), .rst (rst),
      .m_cyc (m_cyc), .m_stb (m_stb), .m_we (m_we), .m_adr (m_adr),
      .m_dat_w (m_dat_w), .m_sel (m_sel),
      .m_ack (m_ack), .m_err (m_err), .m_dat_r (m_dat_r),
      .s_cyc (s_cyc), .s_stb (s_stb), .s_we (s_we), .s_adr (s_adr),
      .s_dat_w (s_dat_w), .s_sel (s_sel),
      .s_ack (s_ack), .s_err (s_err), .s_dat_r (s_dat_r)
   );

   // Slave models: slot 3 is disabled and misbehaves on purpose
   for (genvar j = 0; j < NS; j++) begin : g_slv
      if (j == 3) begin : g_rogue
         assign s_ack[j]   = 1'b1;
         assign s_err[j]   = 1'b0;
         assign s_dat_r[j] = '1;
      end else begin : g_good
         assign s_ack[j]   = s_cyc[j] & s_stb[j] & ~force_err[j];
         assign s_err[j]   = s_cyc[j] & s_stb[j] & force_err[j];
         assign s_dat_r[j] = 32'hD000_0000 | (32'(j) << 16) | 32'(s_adr[j]);
      end
      always_ff @(posedge clk) begin
         if (rst) wr_last[j] <= '0;
         else if (s_cyc[j] && s_stb[j] && s_we[j]) wr_last[j] <= s_dat_w[j];
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input int i, input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
      m_cyc[i] = 1'b1; m_stb[i] = 1'b1; m_we[i] = w;
      m_adr[i] = a; m_dat_w[i] = d; m_sel[i] = '1;
   endtask

   task automatic release_all();
      @(negedge clk);
      m_cyc = '0; m_stb = '0; m_we = '0; m_adr = '0; m_dat_w = '0; m_sel = '0;
      @(negedge clk);
   endtask

   task automatic t_idle();
      @(negedge clk); #0.5;
      chk("R1 s_cyc in reset", 64'(s_cyc), 64'h0);
      chk("R1 s_stb in reset", 64'(s_stb), 64'h0);
      chk("R1 m_ack|m_err in reset", 64'(m_ack | m_err), 64'h0);
   endtask

   task automatic t_decode();
      @(negedge clk); drive(0, 16'h1234, 1'b0, '0); #0.5;
      chk("R2 slot1 select", 64'(s_cyc), 64'b0010);
      chk("R4 ack to owner", 64'(m_ack), 64'b0001);
      chk("R4 read data slot1", 64'(m_dat_r[0]), 64'hD001_1234);
      @(negedge clk); drive(0, 16'h0123, 1'b0, '0); #0.5;
      chk("R3 overlap picks slot0", 64'(s_cyc), 64'b0001);
      chk("R3 read data slot0", 64'(m_dat_r[0]), 64'hD000_0123);
      @(negedge clk); drive(0, 16'h3FFF, 1'b0, '0); #0.5;
      chk("R2 slot2 select", 64'(s_cyc), 64'b0100);
      chk("R4 read data slot2", 64'(m_dat_r[0]), 64'hD002_3FFF);
      release_all();
   endtask

   task automatic t_unmapped();
      @(negedge clk); drive(0, 16'h8000, 1'b0, '0); #0.5;
      chk("R6 err on hole", 64'(m_err), 64'b0001);
      chk("R6 no slave strobed", 64'(s_cyc), 64'h0);
      chk("R6 no ack", 64'(m_ack), 64'h0);
      @(negedge clk); drive(0, 16'h4000, 1'b0, '0); #0.5;
      chk("R10 disabled window is unmapped", 64'(m_err), 64'b0001);
      chk("R10 rogue ack ignored", 64'(m_ack), 64'h0);
      chk("R10 disabled s_cyc", 64'(s_cyc[3]), 64'h0);
      chk("R10 disabled s_adr", 64'(s_adr[3]), 64'h0);
      release_all();
   endtask

   task automatic t_priority();
      @(negedge clk); drive(1, 16'h1000, 1'b0, '0); drive(3, 16'h2000, 1'b0, '0); #0.5;
      chk("R7 lowest master wins", 64'(m_ack), 64'b0010);
      chk("R7 owner address used", 64'(s_cyc), 64'b0010);
      chk("R4 loser data zero", 64'(m_dat_r[3]), 64'h0);
      release_all();
   endtask

   task automatic t_lock();
      @(negedge clk); drive(3, 16'h1004, 1'b0, '0); #0.5;
      chk("R8 master3 alone", 64'(m_ack), 64'b1000);
      @(negedge clk); drive(0, 16'h0008, 1'b0, '0); #0.5;
      chk("R8 owner kept", 64'(m_ack), 64'b1000);
      chk("R8 owner address kept", 64'(s_cyc), 64'b0010);
      @(negedge clk); m_cyc[3] = 1'b0; m_stb[3] = 1'b0; #0.5;
      chk("R8 handover on drop", 64'(m_ack), 64'b0001);
      chk("R8 new owner address", 64'(s_cyc), 64'b0001);
      release_all();
   endtask

   task automatic t_masked_master();
      @(negedge clk); drive(2, 16'h1000, 1'b0, '0); #0.5;
      chk("R9 masked master no slave", 64'(s_cyc), 64'h0);
      chk("R9 masked master no reply", 64'(m_ack | m_err), 64'h0);
      @(negedge clk); drive(3, 16'h0000, 1'b0, '0); #0.5;
      chk("R9 masked master skipped in priority", 64'(m_ack), 64'b1000);
      chk("R9 masked master data zero", 64'(m_dat_r[2]), 64'h0);
      release_all();
   endtask

   task automatic t_write();
      @(negedge clk); drive(0, 16'h2010, 1'b1, 32'hCAFE_F00D); #0.5;
      chk("R5 s_we", 64'(s_we[2]), 64'h1);
      chk("R5 s_dat_w", 64'(s_dat_w[2]), 64'hCAFE_F00D);
      chk("R5 s_adr", 64'(s_adr[2]), 64'h2010);
      chk("R5 s_sel", 64'(s_sel[2]), 64'hF);
      chk("R10 disabled s_dat_w", 64'(s_dat_w[3]), 64'h0);
      release_all();
      chk("R5 write landed in slot2", 64'(wr_last[2]), 64'hCAFE_F00D);
      chk("R5 slot1 untouched", 64'(wr_last[1]), 64'h0);
      chk("R5 slot0 untouched", 64'(wr_last[0]), 64'h0);
   endtask

   task automatic t_slave_err();
      @(negedge clk); force_err[1] = 1'b1; drive(3, 16'h1000, 1'b0, '0); #0.5;
      chk("R11 slave err forwarded", 64'(m_err), 64'b1000);
      chk("R11 no ack with err", 64'(m_ack), 64'h0);
      release_all();
      force_err = '0;
   endtask

   initial begin
      t_idle();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #0.5;
      chk("R1 idle after reset", 64'(s_cyc | s_stb), 64'h0);
      t_decode();
      t_unmapped();
      t_priority();
      t_lock();
      t_masked_master();
      t_write();
      t_slave_err();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule